// File: doc/BRIEF.md
# Modem Status Register with Loopback

This block tracks the four modem handshake inputs of a serial port: clear-to-send, data-set-ready, ring indicate and carrier detect. All four are active low at the pins. Each pin first passes through a synchroniser chain. It then feeds a status byte. The upper nibble of that byte shows the present asserted state of each line. The lower nibble holds sticky change flags that record activity since the last read.

A read strobe returns the byte and clears the change flags at the same clock edge. A change that lands on that edge is kept. Any set change flag raises an interrupt request when the modem-status interrupt enable is high.

For self-test, a loopback input replaces the four pin sources with four bits from the modem control register. Change detection then follows those looped bits instead of the pins. The block also gates the transmitter when automatic flow control is on. Deasserting clear-to-send stops new characters from starting. The character already in flight is allowed to complete.

Top module: `modem_status_reg`

## Requirements
- R1: Change flag bit 0 sets when the effective clear-to-send state changes in either direction, and stays set until a read.
- R2: Change flag bit 1 sets when the effective data-set-ready state changes in either direction.
- R3: Change flag bit 2 sets only when the ring-indicate pin goes from low to high, which is status bit 6 falling from 1 to 0. It does not set on the opposite edge.
- R4: Change flag bit 3 sets when the effective carrier-detect state changes in either direction.
- R5: With loopback low, bits 4, 5, 6 and 7 are the inverses of `cts_n`, `dsr_n`, `ri_n` and `cd_n`. A pin change shows in the byte on the third rising edge after it, because it passes two synchroniser stages and then the status register.
- R6: With loopback high, bits 4 to 7 equal `lb_rts`, `lb_dtr`, `lb_aux2` and `lb_aux3` one edge after they are driven. Change flags follow these bits, and pin activity has no effect on the byte.
- R7: `msi_irq` is high exactly when `msi_en` is high and any of bits 0 to 3 is set.
- R8: When `auto_cts_en` is high and clear-to-send is deasserted (pin high), `tx_allow` goes low. It changes only on an edge where `tx_busy` is low, so a character in progress is never cut off. Once clear-to-send is asserted again, `tx_allow` returns high.
- R9: An edge with `rd_stb` high clears bits 0 to 3, except a flag whose change is detected on that same edge, which stays set.
- R10: A synchronous reset leaves the byte at 0x00, `msi_irq` low and `tx_allow` high. The synchroniser stages are preset to the inactive (high) pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring-indicate pin, active low |
| cd_n | input | 1 | Carrier-detect pin, active low |
| loopback | input | 1 | Selects control-register bits as status sources |
| lb_rts | input | 1 | Control-register request-to-send bit (loops to bit 4) |
| lb_dtr | input | 1 | Control-register terminal-ready bit (loops to bit 5) |
| lb_aux2 | input | 1 | Control-register bit 2 (loops to bit 6) |
| lb_aux3 | input | 1 | Control-register bit 3 (loops to bit 7) |
| msi_en | input | 1 | Modem-status interrupt enable |
| rd_stb | input | 1 | Register read strobe; clears change flags |
| tx_busy | input | 1 | Transmitter is sending a character |
| auto_cts_en | input | 1 | Enables automatic clear-to-send flow control |
| rd_data | output | 8 | Status byte: [7:4] state, [3:0] change flags |
| msi_irq | output | 1 | Modem-status interrupt request |
| tx_allow | output | 1 | Transmitter may start a new character |

## Verification
The bench drives every ordered pair of the 16 pin patterns, and then every ordered pair of the 16 loopback patterns. For each transition it computes the expected byte and interrupt arithmetically. This catches a ring flag that fires on both edges or on the wrong edge, and a loopback path with swapped or inverted bits. It also catches flags that follow the pins while loopback is selected. A change is timed to land on the read edge to expose a clear that wins over a fresh set, which would lose an event. The flow-control sequence deasserts clear-to-send while a character is in flight. A gate that acted at once would drop `tx_allow` mid-character, and one that never released would keep it low after clear-to-send returns.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int NSIG = 4;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_CD  = 3;
  localparam int BYTE_W  = 2 * NSIG;
  typedef logic [NSIG-1:0] sig_vec_t;
  // only the ring line flags its trailing edge (status falling)
  localparam sig_vec_t TRAIL_ONLY = sig_vec_t'(1 << IDX_RI);
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/msr_delta.sv
module msr_delta
  import msr_pkg::*;
#(
  parameter sig_vec_t TRAIL_MASK = TRAIL_ONLY
) (
  input  logic     clk,
  input  logic     rst,
  input  sig_vec_t stat_d,
  input  logic     rd_clr,
  output sig_vec_t stat_q,
  output sig_vec_t delta_q
);
  sig_vec_t edge_hit;

  for (genvar i = 0; i < NSIG; i++) begin : g_edge
    if (TRAIL_MASK[i]) begin : g_trail
      assign edge_hit[i] = stat_q[i] & ~stat_d[i];
    end else begin : g_both
      assign edge_hit[i] = stat_q[i] ^ stat_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      delta_q <= '0;
    end else begin
      stat_q  <= stat_d;
      delta_q <= (rd_clr ? '0 : delta_q) | edge_hit;
    end
  end

  // R1: flags are sticky until a read
  assert_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    !rd_clr |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  // R3: ring flag rises only on a falling status bit
  assert_ri_trailing_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(delta_q[IDX_RI]) && delta_q[IDX_RI]) |->
      ($past(stat_q[IDX_RI]) && !stat_q[IDX_RI]));

  // R9: a read with no concurrent change empties the flags
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && stat_d == stat_q) |=> (delta_q == '0));

  // R10: reset empties the flags
  assert_reset_flags_R10: assert property (@(posedge clk)
    rst |=> (delta_q == '0));
endmodule

// File: rtl/msr_cts_gate.sv
module msr_cts_gate (
  input  logic clk,
  input  logic rst,
  input  logic auto_en,
  input  logic cts_on,
  input  logic tx_busy,
  output logic tx_allow
);
  logic hold_q;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b0;
    else if (!tx_busy) hold_q <= auto_en & ~cts_on;
  end

  assign tx_allow = ~hold_q;

  // R8: gate never moves while a character is in flight
  assert_gate_stable_R8: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> $stable(tx_allow));
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              cd_n,
  input  logic              loopback,
  input  logic              lb_rts,
  input  logic              lb_dtr,
  input  logic              lb_aux2,
  input  logic              lb_aux3,
  input  logic              msi_en,
  input  logic              rd_stb,
  input  logic              tx_busy,
  input  logic              auto_cts_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              msi_irq,
  output logic              tx_allow
);
  sig_vec_t pin_raw, pin_sync, loop_src, stat_d, stat_q, delta_q;

  assign pin_raw  = {cd_n, ri_n, dsr_n, cts_n};
  assign loop_src = {lb_aux3, lb_aux2, lb_dtr, lb_rts};

  msr_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst(rst), .d(pin_raw), .q(pin_sync)
  );

  assign stat_d = loopback ? loop_src : ~pin_sync;

  msr_delta #(.TRAIL_MASK(TRAIL_ONLY)) u_delta (
    .clk(clk), .rst(rst), .stat_d(stat_d), .rd_clr(rd_stb),
    .stat_q(stat_q), .delta_q(delta_q)
  );

  msr_cts_gate u_gate (
    .clk(clk), .rst(rst), .auto_en(auto_cts_en), .cts_on(stat_d[IDX_CTS]),
    .tx_busy(tx_busy), .tx_allow(tx_allow)
  );

  assign rd_data = {stat_q, delta_q};
  assign msi_irq = msi_en & (|delta_q);

  // R6: in loopback the state nibble tracks the control bits
  assert_loop_src_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(loopback)) |-> (rd_data[BYTE_W-1:NSIG] == $past(loop_src)));

  // R7: interrupt needs enable and a pending flag
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (rst)
    msi_irq |-> (msi_en && rd_data[NSIG-1:0] != '0));
endmodule

// File: tb/tb_modem_status_reg.sv
module tb_modem_status_reg;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] pins = 4'hF;
  logic [3:0] mcr = 4'h0;
  logic loopback = 1'b0, msi_en = 1'b0, rd_stb = 1'b0;
  logic tx_busy = 1'b0, auto_cts_en = 1'b0;
  logic [7:0] rd_data;
  logic msi_irq, tx_allow;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  modem_status_reg dut (
    .clk(clk), .rst(rst),
    .cts_n(pins[0]), .dsr_n(pins[1]), .ri_n(pins[2]), .cd_n(pins[3]),
    .loopback(loopback),
    .lb_rts(mcr[0]), .lb_dtr(mcr[1]), .lb_aux2(mcr[2]), .lb_aux3(mcr[3]),
    .msi_en(msi_en), .rd_stb(rd_stb), .tx_busy(tx_busy),
    .auto_cts_en(auto_cts_en),
    .rd_data(rd_data), .msi_irq(msi_irq), .tx_allow(tx_allow)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    step(1);
    rd_stb = 1'b0;
  endtask

  function automatic logic [3:0] exp_delta(input logic [3:0] s_old, input logic [3:0] s_new);
    logic [3:0] d;
    d = s_old ^ s_new;
    d[2] = s_old[2] & ~s_new[2]; // ring: status falling = pin rising
    return d;
  endfunction

  initial begin
    logic [3:0] sa, sb, dl;
    step(3);
    rst = 1'b0;
    step(1);
    // R10 reset state
    chk("R10 byte", rd_data, 8'h00);
    chk("R10 irq", {7'd0, msi_irq}, 8'h00);
    chk("R10 tx_allow", {7'd0, tx_allow}, 8'h01);

    // R1 R2 R3 R4 R5 R7: all pin transitions
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        pins = 4'(a);
        step(4);
        do_read();
        msi_en = 1'(a ^ b);
        pins = 4'(b);
        step(2);
        sa = ~4'(a);
        chk("R5 latency hold", rd_data, {sa, 4'h0});
        step(1);
        sb = ~4'(b);
        dl = exp_delta(sa, sb);
        chk("R1 R2 R3 R4 R5 pin byte", rd_data, {sb, dl});
        chk("R7 irq", {7'd0, msi_irq}, {7'd0, msi_en & (|dl)});
      end
    end

    // R9: change on the read edge survives the clear
    pins = 4'hF;
    step(4);
    do_read();
    chk("R9 cleared", rd_data, 8'h00);
    pins = 4'hE;
    step(2);
    rd_stb = 1'b1;
    step(1);
    rd_stb = 1'b0;
    chk("R9 same-edge change kept", rd_data, 8'h11);
    do_read();
    chk("R9 read clears", rd_data, 8'h10);
    pins = 4'hF;
    step(4);
    do_read();

    // R6: loopback sweep
    loopback = 1'b1;
    mcr = 4'h0;
    step(2);
    do_read();
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        mcr = 4'(a);
        step(1);
        do_read();
        mcr = 4'(b);
        step(1);
        chk("R6 R3 loop byte", rd_data, {4'(b), exp_delta(4'(a), 4'(b))});
      end
    end
    // R6: pins ignored in loopback
    mcr = 4'h5;
    step(1);
    do_read();
    pins = 4'h0;
    step(4);
    chk("R6 pins ignored", rd_data, 8'h50);
    pins = 4'hA;
    step(4);
    chk("R6 pins ignored again", rd_data, 8'h50);
    pins = 4'hF;
    mcr = 4'h0;
    step(4);
    loopback = 1'b0;
    step(1);
    do_read();

    // R8: auto flow-control gate
    pins[0] = 1'b0;
    auto_cts_en = 1'b1;
    step(4);
    chk("R8 allow with cts asserted", {7'd0, tx_allow}, 8'h01);
    tx_busy = 1'b1;
    pins[0] = 1'b1;
    step(4);
    chk("R8 busy keeps allow", {7'd0, tx_allow}, 8'h01);
    tx_busy = 1'b0;
    step(1);
    chk("R8 stop after char", {7'd0, tx_allow}, 8'h00);
    pins[0] = 1'b0;
    step(2);
    chk("R8 still stopped", {7'd0, tx_allow}, 8'h00);
    step(1);
    chk("R8 resume", {7'd0, tx_allow}, 8'h01);
    auto_cts_en = 1'b0;
    pins[0] = 1'b1;
    step(4);
    chk("R8 disabled never stops", {7'd0, tx_allow}, 8'h01);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule